// File: doc/BRIEF.md
# Pseudorandom Pattern Sync Monitor

This receive-side monitor takes a serial bit stream carrying a pseudorandom sequence, locks onto it and then compares every further bit with a copy regenerated on chip. The feedback polynomial is set at run time by a tap mask and an order. The search needs no prior knowledge of the stream's phase. It takes the first received bits as the generator state and then asks for a clean run of predicted bits before it declares lock.

While locked, the monitor keeps a sliding window of recent mismatches. Too many errors close together drop the lock, raise a one-cycle loss strobe and start a new search. Two wide accumulators run alongside. One counts every enabled bit and the other counts mismatches seen while locked. A rising edge on the latch input moves both totals to stable output registers and starts a new measuring period, so the error rate over any interval can be read out.

Top module: `prbs_sync_mon`

## Requirements
- R1: After reset `locked_o` and `los_o` are low and both `bit_cnt_o` and `err_cnt_o` read zero.
- R2: From the search state the monitor takes `order_i` enabled bits as its seed. It then needs 50 further enabled bits that each equal the XOR of the previous bits selected by `taps_i` (mask bit k selects the bit received k+1 enabled cycles earlier). `locked_o` rises right after the clock edge that takes in bit number order+50, and not before.
- R3: A mismatch during the confirmation run sends the monitor back to seeding. Lock is then declared only after another order+50 enabled bits, counted from the bit after the mismatch.
- R4: While locked, each received bit that differs from the regenerated sequence adds exactly one to the error accumulator. A lone error does not upset the later predictions, and mismatches seen while not locked are never counted.
- R5: While locked, a mismatch that makes 6 errors among the last 64 enabled bits drops `locked_o` right after that edge, and `los_o` is high for exactly that one cycle. A sixth error that falls after the oldest of five earlier errors has left the 64-bit window keeps the lock.
- R6: After a loss the search starts again. Lock returns order+50 clean enabled bits after the bit that caused the loss.
- R7: The bit accumulator adds one for every cycle with `en_i` high, locked or not, and adds nothing when `en_i` is low.
- R8: A rising edge on `latch_i` copies both accumulators into `bit_cnt_o` and `err_cnt_o` and clears them. Between edges the output registers keep their values.
- R9: The polynomial follows `taps_i` and `order_i` at run time. An order-15 pattern locks in 65 bits just as an order-7 pattern locks in 57.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receive bit valid this cycle |
| rx_i | input | 1 | Received data bit |
| order_i | input | 6 | Polynomial order, 1 to 32 |
| taps_i | input | 32 | Feedback tap mask over the bit history |
| latch_i | input | 1 | Snapshot-and-clear control, acts on a rising edge |
| locked_o | output | 1 | Pattern lock held |
| los_o | output | 1 | One-cycle strobe on loss of lock |
| bit_cnt_o | output | 48 | Latched enabled-bit count |
| err_cnt_o | output | 48 | Latched error count |

## Verification
A seed or run counter that is off by one shows at once as `locked_o` rising one bit early or late. For that reason lock is sampled on both sides of the order+50 boundary, for two polynomial orders and after a restart. A history register fed with received bits instead of predicted bits while locked would turn each lone error into several, and the error count read at the next latch would show it. A window that ages errors wrongly shows up on the very bit that should or should not drop the lock. Accumulator faults show up in the latched totals after each period, and those periods include idle cycles and random gaps.

// File: rtl/prbs_sync_pkg.sv
package prbs_sync_pkg;
  typedef enum logic [1:0] {
    ST_SEED    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCK    = 2'd2
  } sync_st_e;
endpackage

// File: rtl/prbs_seek_fsm.sv
module prbs_seek_fsm
  import prbs_sync_pkg::*;
#(
  parameter int HIST_W   = 32,
  parameter int CONF_LEN = 50
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          rx_i,
  input  logic [$clog2(HIST_W+1)-1:0]   order_i,
  input  logic [HIST_W-1:0]             taps_i,
  input  logic                          drop_i,
  output logic                          mismatch_o,
  output logic                          locked_o
);
  localparam int OW = $clog2(HIST_W + 1);
  localparam int CW = $clog2(CONF_LEN + 1);

  sync_st_e          st_q;
  logic [HIST_W-1:0] hist_q;
  logic [OW-1:0]     seed_q;
  logic [CW-1:0]     run_q;
  logic              pred;
  logic [OW:0]       seed_nxt;

  assign pred       = ^(hist_q & taps_i);
  assign mismatch_o = rx_i ^ pred;
  assign locked_o   = (st_q == ST_LOCK);
  assign seed_nxt   = (OW+1)'(seed_q) + (OW+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_SEED;
      hist_q <= '0;
      seed_q <= '0;
      run_q  <= '0;
    end else if (en_i) begin
      unique case (st_q)
        ST_SEED: begin
          hist_q <= {hist_q[HIST_W-2:0], rx_i};
          if (seed_nxt >= {1'b0, order_i}) begin
            st_q  <= ST_CONFIRM;
            run_q <= '0;
          end else begin
            seed_q <= seed_q + 1'b1;
          end
        end
        ST_CONFIRM: begin
          hist_q <= {hist_q[HIST_W-2:0], rx_i};
          if (mismatch_o) begin
            st_q   <= ST_SEED;
            seed_q <= '0;
          end else if (run_q == CW'(CONF_LEN - 1)) begin
            st_q <= ST_LOCK;
          end else begin
            run_q <= run_q + 1'b1;
          end
        end
        ST_LOCK: begin
          if (drop_i) begin
            st_q   <= ST_SEED;
            seed_q <= '0;
            hist_q <= {hist_q[HIST_W-2:0], rx_i};
          end else begin
            // free-run on the local copy so line errors do not propagate
            hist_q <= {hist_q[HIST_W-2:0], pred};
          end
        end
        default: st_q <= ST_SEED;
      endcase
    end
  end
endmodule

// File: rtl/err_density_win.sv
module err_density_win #(
  parameter int WIN    = 64,
  parameter int THRESH = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       step_i,
  input  logic                       err_i,
  input  logic                       clr_i,
  output logic                       drop_o,
  output logic [$clog2(WIN+1)-1:0]   pop_o
);
  localparam int PW = $clog2(WIN + 1);

  logic [WIN-1:0] win_q;
  logic [PW-1:0]  pop_q;
  logic [PW-1:0]  pop_nxt;

  assign pop_nxt = pop_q + PW'(err_i) - PW'(win_q[WIN-1]);
  assign drop_o  = step_i && (pop_nxt >= PW'(THRESH));
  assign pop_o   = pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      pop_q <= '0;
    end else if (clr_i || drop_o) begin
      win_q <= '0;
      pop_q <= '0;
    end else if (step_i) begin
      win_q <= {win_q[WIN-2:0], err_i};
      pop_q <= pop_nxt;
    end
  end
endmodule

// File: rtl/sat_acc.sv
module sat_acc #(
  parameter int W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         snap_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      hold_o <= '0;
    end else if (snap_i) begin
      hold_o <= acc_o;
      acc_o  <= W'(inc_i);
    end else if (inc_i && (acc_o != '1)) begin
      acc_o <= acc_o + 1'b1;
    end
  end
endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon #(
  parameter int HIST_W   = 32,
  parameter int CONF_LEN = 50,
  parameter int WIN      = 64,
  parameter int THRESH   = 6,
  parameter int CNT_W    = 48
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          en_i,
  input  logic                          rx_i,
  input  logic [$clog2(HIST_W+1)-1:0]   order_i,
  input  logic [HIST_W-1:0]             taps_i,
  input  logic                          latch_i,
  output logic                          locked_o,
  output logic                          los_o,
  output logic [CNT_W-1:0]              bit_cnt_o,
  output logic [CNT_W-1:0]              err_cnt_o
);
  localparam int PW = $clog2(WIN + 1);

  logic             mismatch, drop, latch_q, latch_edge, los_q;
  logic [PW-1:0]    pop_w;
  logic [CNT_W-1:0] bit_acc, err_acc;

  assign latch_edge = latch_i & ~latch_q;
  assign los_o      = los_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b0;
      los_q   <= 1'b0;
    end else begin
      latch_q <= latch_i;
      los_q   <= drop;
    end
  end

  prbs_seek_fsm #(.HIST_W(HIST_W), .CONF_LEN(CONF_LEN)) u_fsm (
    .clk_i, .rst_ni, .en_i, .rx_i, .order_i, .taps_i,
    .drop_i     (drop),
    .mismatch_o (mismatch),
    .locked_o   (locked_o)
  );

  err_density_win #(.WIN(WIN), .THRESH(THRESH)) u_win (
    .clk_i, .rst_ni,
    .step_i (en_i & locked_o),
    .err_i  (mismatch),
    .clr_i  (~locked_o),
    .drop_o (drop),
    .pop_o  (pop_w)
  );

  sat_acc #(.W(CNT_W)) u_bits (
    .clk_i, .rst_ni,
    .inc_i  (en_i),
    .snap_i (latch_edge),
    .acc_o  (bit_acc),
    .hold_o (bit_cnt_o)
  );

  sat_acc #(.W(CNT_W)) u_errs (
    .clk_i, .rst_ni,
    .inc_i  (en_i & locked_o & mismatch),
    .snap_i (latch_edge),
    .acc_o  (err_acc),
    .hold_o (err_cnt_o)
  );
endmodule

// File: rtl/prbs_sync_chk.sv
module prbs_sync_chk #(
  parameter int W      = 48,
  parameter int PW     = 7,
  parameter int THRESH = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          latch_edge,
  input logic          locked_o,
  input logic          los_o,
  input logic [PW-1:0] pop,
  input logic [W-1:0]  bit_acc,
  input logic [W-1:0]  err_acc
);
  // R5
  los_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_o |=> !los_o);
  // R5
  los_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_o |-> !locked_o);
  // R5
  pop_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (pop < PW'(THRESH)));
  // R5
  lock_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> los_o);
  // R7
  bit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !latch_edge && (bit_acc != '1)) |=> (bit_acc == $past(bit_acc) + 1'b1));
  // R4
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && !latch_edge) |=> $stable(err_acc));
  // R8
  snap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_edge && !en_i) |=> (bit_acc == '0) && (err_acc == '0));
endmodule

bind prbs_sync_mon prbs_sync_chk #(.W(CNT_W), .PW($clog2(WIN+1)), .THRESH(THRESH)) u_chk (
  .clk_i, .rst_ni, .en_i,
  .latch_edge (latch_edge),
  .locked_o   (locked_o),
  .los_o      (los_o),
  .pop        (pop_w),
  .bit_acc    (bit_acc),
  .err_acc    (err_acc)
);

// File: tb/tb_prbs_sync_mon.sv
module tb_prbs_sync_mon;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        rx_i = 1'b0;
  logic [5:0]  order_i = 6'd7;
  logic [31:0] taps_i = 32'h60;
  logic        latch_i = 1'b0;
  logic        locked_o, los_o;
  logic [47:0] bit_cnt_o, err_cnt_o;

  int unsigned total = 0, bad = 0;
  logic [31:0] g = 32'h1;
  longint unsigned exp_bits = 0, exp_errs = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prbs_sync_mon dut (.*);

  function automatic logic gen_next(input logic [31:0] s, input logic [31:0] t);
    return ^(s & t);
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic flip);
    logic b;
    b = gen_next(g, taps_i);
    g = {g[30:0], b};
    rx_i = b ^ flip;
    en_i = 1'b1;
    exp_bits++;
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    en_i = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) push(1'b0);
  endtask

  task automatic idle(input int n);
    en_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #(CLK_PERIOD/4);
    end
  endtask

  task automatic latch_and_check(input string req);
    latch_i = 1'b1;
    idle(1);
    latch_i = 1'b0;
    idle(1);
    check({req, " bits"}, bit_cnt_o, exp_bits);
    check({req, " errs"}, err_cnt_o, exp_errs);
    exp_bits = 0;
    exp_errs = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    en_i = 1'b0;
    latch_i = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    exp_bits = 0;
    exp_errs = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int since;
    void'($urandom(32'd4242));
    do_reset();
    // R1
    check("R1 locked", locked_o, 0);
    check("R1 los", los_o, 0);
    check("R1 bit_cnt", bit_cnt_o, 0);
    check("R1 err_cnt", err_cnt_o, 0);

    // R2: order 7 locks on bit 57
    push_n(56);
    check("R2 not yet locked", locked_o, 0);
    push(1'b0);
    check("R2 locked at n+50", locked_o, 1);

    // R4: lone errors counted once each
    push_n(100);
    push(1'b1); exp_errs++;
    push_n(100);
    push(1'b1); exp_errs++;
    push_n(30);
    check("R4 lock kept", locked_o, 1);
    latch_and_check("R4");

    // R7, R8: idle cycles add nothing, outputs hold between edges
    idle(10);
    latch_and_check("R7 idle");
    push_n(20);
    check("R8 hold bits", bit_cnt_o, 0);

    // R5: density window
    push_n(100);
    for (int off = 0; off <= 64; off++) begin
      logic f;
      f = (off % 12 == 0 && off <= 48) || off == 64;
      if (f) exp_errs++;
      push(f);
    end
    check("R5 five in window keeps lock", locked_o, 1);
    push_n(5);
    push(1'b1); exp_errs++;
    check("R5 sixth drops lock", locked_o, 0);
    check("R5 los strobe", los_o, 1);

    // R6: relock after loss
    push(1'b0);
    check("R5 los one cycle", los_o, 0);
    push_n(55);
    check("R6 not relocked early", locked_o, 0);
    push(1'b0);
    check("R6 relocked", locked_o, 1);
    latch_and_check("R5 R6");

    // R3, R9: order 15 with a confirm-phase error
    taps_i = 32'h6000;
    order_i = 6'd15;
    g = 32'h5a5;
    do_reset();
    push_n(35);
    push(1'b1);
    push_n(64);
    check("R3 R9 not locked", locked_o, 0);
    push(1'b0);
    check("R3 R9 locked after restart", locked_o, 1);
    latch_and_check("R4 search errors ignored");

    // random phase: gaps and sparse errors while locked
    since = 80;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 4 == 0) idle(1);
      else if (since >= 80 && $urandom % 40 == 0) begin
        push(1'b1); exp_errs++; since = 0;
      end else begin
        push(1'b0); since++;
      end
    end
    check("R4 random lock kept", locked_o, 1);
    latch_and_check("R7 R8 random");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule